// File: doc/BRIEF.md
# SPI Command-Packet Host Master

This block is the host side of a register-style SPI link. A local client gives it an 8-bit opcode and a 24-bit payload over a valid/ready port. The block turns each command into one or more fixed 32-bit frames on SCK, SS and MOSI and shifts in the target's answer from MISO at the same time. For every frame it returns the received status byte and the 24-bit reply field, together with a one-cycle done pulse. The status byte is also decoded into an accepted flag and a reply-valid flag.

The target ignores all traffic until it has seen an init packet. For that reason the master sends an init frame on its own after reset, and it accepts no command until that frame is complete. On this link a read only arms the target, and the data arrives in a later frame. A small sequencer therefore appends fetch frames (opcode 0x00) after read requests: one fetch after a single-word request, and four after a vector request. The clients see each frame as its own response, and fetch frames are marked as such. If a fetch returns with its reply-valid bit clear, a sticky error flag is set.

Top module: `spi_cmd_master`

## Requirements
- R1: While reset is asserted and right after it is released, spi_ss_n is 1, spi_sck is 0, cmd_ready is 0 and fetch_err is 0. The first frame after reset is always opcode 0x01 with a zero payload, started without any command. cmd_ready rises only after that frame has finished.
- R2: Each frame holds SS low for exactly 32 rising SCK edges. Bits go out least-significant first: opcode bits 0 to 7, then payload bits 0 to 23. MOSI changes only while SCK is low (SPI mode 0).
- R3: SCK idles low whenever SS is high. Within a frame, the SCK period is DIV system clocks (DIV at least 4).
- R4: Between two frames, SS stays high for at least 2*DIV system clocks.
- R5: A command is taken in a cycle where cmd_valid and cmd_ready are both 1. cmd_ready then stays 0 until every frame belonging to that command has finished, and it is never 1 while SS is low.
- R6: Each frame produces exactly one one-cycle rsp_valid pulse. rsp_status holds the first 8 MISO bits and rsp_data holds the last 24, both least-significant first.
- R7: rsp_accepted equals status bit 5 and rsp_data_ok equals status bit 6 of the same frame.
- R8: Opcodes 0x03 and 0x05 are followed by exactly one fetch frame (opcode 0x00, payload 0). Its response has rsp_fetch=1 and carries the requested word.
- R9: Opcode 0x07 is followed by exactly VEC_LEN fetch frames. The target's elements come back in index order, one per fetch.
- R10: Any other opcode, including unknown values, sends exactly one frame, and its response has rsp_fetch=0.
- R11: fetch_err goes to 1 after a fetch frame returns with status bit 6 clear, and it stays 1 until reset. A vector request still sends all VEC_LEN fetch frames when this happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 8 | Opcode placed in the first frame byte |
| cmd_payload | input | 24 | Payload placed in the last three frame bytes |
| rsp_valid | output | 1 | One-cycle pulse per finished frame |
| rsp_status | output | 8 | Status byte received during the opcode byte |
| rsp_data | output | 24 | Reply field received during the payload bytes |
| rsp_accepted | output | 1 | Target accepted the frame (status bit 5) |
| rsp_data_ok | output | 1 | Reply field valid (status bit 6) |
| rsp_fetch | output | 1 | Response belongs to an automatic fetch frame |
| fetch_err | output | 1 | Sticky: some fetch returned without valid data |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_ss_n | output | 1 | Active-low target select |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
Some rules hold on every cycle, and the assertions check them there: SCK low whenever SS is high, MOSI steady while SCK is high, the minimum SS-high gap before each frame, single-cycle response pulses, no command acceptance while a frame is in flight, and the stickiness of the error flag. The bench's scenarios cover what depends on content and sequence. Its behavioural target checks the wire bit order, the automatic init frame, the number of fetch frames per opcode, the order of vector elements, the status decoding, and the raising of the error flag when the target withholds data.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_NOP     = 8'h00;
  localparam logic [OP_W-1:0] OP_INIT    = 8'h01;
  localparam logic [OP_W-1:0] OP_ASK_INV = 8'h03;
  localparam logic [OP_W-1:0] OP_ASK_LED = 8'h05;
  localparam logic [OP_W-1:0] OP_ASK_VEC = 8'h07;

  // status byte bit positions decoded by the master
  localparam int STAT_ACCEPT = 5;
  localparam int STAT_VALID  = 6;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SHIFT, ENG_TAIL, ENG_GAP} eng_state_t;
  typedef enum logic [1:0] {SEQ_BOOT, SEQ_IDLE, SEQ_WAIT} seq_state_t;

  // number of fetch frames that must trail a given opcode
  function automatic int unsigned trailing_fetches(input logic [OP_W-1:0] op,
                                                   input int unsigned vec_len);
    if (op == OP_ASK_INV || op == OP_ASK_LED) return 1;
    if (op == OP_ASK_VEC) return vec_len;
    return 0;
  endfunction

endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int DIV     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               ready,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sck,
  output logic               ss_n,
  output logic               mosi,
  input  logic               miso
);

  localparam int HALF    = DIV / 2;
  localparam int GAP_CYC = 2 * DIV;
  localparam int CNT_W   = $clog2(GAP_CYC + 1);
  localparam int BIT_W   = $clog2(FRAME_W);

  eng_state_t         st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] rxo_q, rxo_d;
  logic               sck_q, sck_d;
  logic               ss_q, ss_d;
  logic               mosi_q, mosi_d;
  logic               done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    rxo_d  = rxo_q;
    sck_d  = sck_q;
    ss_d   = ss_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (start) begin
          tx_d   = word;
          mosi_d = word[0];
          ss_d   = 1'b0;
          cnt_d  = '0;
          bit_d  = '0;
          st_d   = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(HALF - 1)) begin
          sck_d = 1'b1;
          rx_d  = {miso, rx_q[FRAME_W-1:1]};
        end
        if (cnt_q == CNT_W'(DIV - 1)) begin
          sck_d = 1'b0;
          cnt_d = '0;
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            st_d   = ENG_TAIL;
            done_d = 1'b1;
            rxo_d  = rx_q;
          end else begin
            bit_d  = bit_q + 1'b1;
            tx_d   = tx_q >> 1;
            mosi_d = tx_q[1];
          end
        end
      end
      ENG_TAIL: begin
        cnt_d  = cnt_q + 1'b1;
        mosi_d = 1'b0;
        if (cnt_q == CNT_W'(HALF - 1)) begin
          ss_d  = 1'b1;
          cnt_d = '0;
          st_d  = ENG_GAP;
        end
      end
      default: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
          cnt_d = '0;
          st_d  = ENG_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxo_q  <= '0;
      sck_q  <= 1'b0;
      ss_q   <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      rxo_q  <= rxo_d;
      sck_q  <= sck_d;
      ss_q   <= ss_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
    end
  end

  assign ready   = (st_q == ENG_IDLE);
  assign done    = done_q;
  assign rx_word = rxo_q;
  assign sck     = sck_q;
  assign ss_n    = ss_q;
  assign mosi    = mosi_q;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int PAY_W   = 24,
  parameter int VEC_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [OP_W-1:0]       cmd_op,
  input  logic [PAY_W-1:0]      cmd_payload,
  input  logic                  eng_ready,
  input  logic                  eng_done,
  input  logic                  eng_valid_bit,
  output logic                  eng_start,
  output logic [OP_W+PAY_W-1:0] eng_word,
  output logic                  cur_fetch,
  output logic                  fetch_err
);

  localparam int FCNT_W = $clog2(VEC_LEN + 1);

  seq_state_t        st_q, st_d;
  logic [FCNT_W-1:0] left_q, left_d;
  logic              cf_q, cf_d;
  logic              err_q, err_d;

  always_comb begin
    st_d      = st_q;
    left_d    = left_q;
    cf_d      = cf_q;
    eng_start = 1'b0;
    eng_word  = '0;
    unique case (st_q)
      SEQ_BOOT: begin
        if (eng_ready) begin
          eng_start = 1'b1;
          eng_word  = {{PAY_W{1'b0}}, OP_INIT};
          left_d    = '0;
          cf_d      = 1'b0;
          st_d      = SEQ_WAIT;
        end
      end
      SEQ_IDLE: begin
        if (cmd_valid) begin
          eng_start = 1'b1;
          eng_word  = {cmd_payload, cmd_op};
          left_d    = FCNT_W'(trailing_fetches(cmd_op, VEC_LEN));
          cf_d      = 1'b0;
          st_d      = SEQ_WAIT;
        end
      end
      default: begin
        if (eng_ready) begin
          if (left_q != '0) begin
            eng_start = 1'b1;
            eng_word  = {{PAY_W{1'b0}}, OP_NOP};
            left_d    = left_q - 1'b1;
            cf_d      = 1'b1;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
      end
    endcase
    err_d = err_q | (eng_done & cf_q & ~eng_valid_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_BOOT;
      left_q <= '0;
      cf_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      cf_q   <= cf_d;
      err_q  <= err_d;
    end
  end

  assign cmd_ready = (st_q == SEQ_IDLE);
  assign cur_fetch = cf_q;
  assign fetch_err = err_q;

endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int PAY_W   = 24,
  parameter int VEC_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_op,
  input  logic [PAY_W-1:0] cmd_payload,
  output logic             rsp_valid,
  output logic [7:0]       rsp_status,
  output logic [PAY_W-1:0] rsp_data,
  output logic             rsp_accepted,
  output logic             rsp_data_ok,
  output logic             rsp_fetch,
  output logic             fetch_err,
  output logic             spi_sck,
  output logic             spi_ss_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int FRAME_W = OP_W + PAY_W;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               eng_ready;
  logic               eng_done;
  logic               eng_start;
  logic [FRAME_W-1:0] eng_word;
  logic [FRAME_W-1:0] eng_rx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_cmd_seq #(.PAY_W(PAY_W), .VEC_LEN(VEC_LEN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_payload   (cmd_payload),
    .eng_ready     (eng_ready),
    .eng_done      (eng_done),
    .eng_valid_bit (eng_rx[STAT_VALID]),
    .eng_start     (eng_start),
    .eng_word      (eng_word),
    .cur_fetch     (rsp_fetch),
    .fetch_err     (fetch_err)
  );

  spi_frame_engine #(.FRAME_W(FRAME_W), .DIV(DIV)) u_eng (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (eng_start),
    .word    (eng_word),
    .ready   (eng_ready),
    .done    (eng_done),
    .rx_word (eng_rx),
    .sck     (spi_sck),
    .ss_n    (spi_ss_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  assign rsp_valid    = eng_done;
  assign rsp_status   = eng_rx[OP_W-1:0];
  assign rsp_data     = eng_rx[FRAME_W-1:OP_W];
  assign rsp_accepted = eng_rx[STAT_ACCEPT];
  assign rsp_data_ok  = eng_rx[STAT_VALID];

endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic spi_sck,
  input logic spi_ss_n,
  input logic spi_mosi,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic fetch_err
);

  localparam int GAP_MIN = 2 * DIV;
  localparam int GW      = $clog2(GAP_MIN + 1);

  logic [GW-1:0] gap_cnt;

  // counts cycles with SS high, saturating at the minimum gap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            gap_cnt <= GW'(GAP_MIN);
    else if (!spi_ss_n)                    gap_cnt <= '0;
    else if (gap_cnt != GW'(GAP_MIN))      gap_cnt <= gap_cnt + 1'b1;
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> !spi_sck);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));

  assert_ss_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ss_n) |-> (gap_cnt >= GW'(GAP_MIN)));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_ss_n);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |=> fetch_err);

endmodule

bind spi_cmd_master spi_cmd_master_chk #(.DIV(DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_sck   (spi_sck),
  .spi_ss_n  (spi_ss_n),
  .spi_mosi  (spi_mosi),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .fetch_err (fetch_err)
);

// File: tb/sim_spi_cmd_master.sv
module sim_spi_cmd_master;

  localparam int DIV  = 4;
  localparam int VEC  = 4;
  localparam int TCK  = 8;
  localparam int NROW = 11;

  // {op, payload, frames, check, expected reply}
  localparam logic [63:0] TBL [NROW] = '{
    {8'h02, 24'h38AE3B, 4'd1, 4'd0, 24'h000000},
    {8'h03, 24'h000000, 4'd2, 4'd1, 24'hC751C4},
    {8'h04, 24'h000003, 4'd1, 4'd0, 24'h000000},
    {8'h05, 24'h000000, 4'd2, 4'd1, 24'h000003},
    {8'h06, 24'h000010, 4'd1, 4'd0, 24'h000000},
    {8'h06, 24'h000020, 4'd1, 4'd0, 24'h000000},
    {8'h06, 24'h000030, 4'd1, 4'd0, 24'h000000},
    {8'h06, 24'h000040, 4'd1, 4'd0, 24'h000000},
    {8'h07, 24'h000000, 4'd5, 4'd1, 24'h000040},
    {8'h09, 24'h123456, 4'd1, 4'd0, 24'h000000},
    {8'h00, 24'h000000, 4'd1, 4'd0, 24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [23:0] cmd_payload = '0;
  logic        cmd_ready, rsp_valid, rsp_accepted, rsp_data_ok, rsp_fetch, fetch_err;
  logic [7:0]  rsp_status;
  logic [23:0] rsp_data;
  logic        spi_sck, spi_ss_n, spi_mosi;
  logic        tgt_miso = 1'b0;

  int total = 0;
  int bad = 0;

  always #(TCK/2) clk = ~clk;

  spi_cmd_master #(.DIV(DIV), .PAY_W(24), .VEC_LEN(VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_payload(cmd_payload), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .rsp_accepted(rsp_accepted),
    .rsp_data_ok(rsp_data_ok), .rsp_fetch(rsp_fetch), .fetch_err(fetch_err),
    .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(tgt_miso)
  );

  // ---------------- behavioural target ----------------
  bit          tgt_init = 0, tgt_accept = 1, tgt_drop = 0, tgt_in = 0;
  int          tgt_k = 0;
  logic [31:0] tgt_out = '0, tgt_rx = '0;
  logic [23:0] pend = '0, inv_reg = '0;
  bit          pend_v = 0;
  logic [2:0]  led_reg = '0;
  logic [23:0] vec [VEC];
  int          wp = 0, rp = 0, qcnt = 0;
  int          frames = 0, bad_len = 0;
  logic [31:0] log_w [64];
  longint      t_rise = 0, min_gap = 64'd1000000000;
  bit          gap_seen = 0;

  task automatic tgt_frame(input logic [31:0] w);
    logic [7:0]  op;
    logic [23:0] pl;
    op = w[7:0];
    pl = w[31:8];
    pend_v = 0;
    if (!tgt_init) begin
      if (op == 8'h01) tgt_init = 1;
    end else begin
      case (op)
        8'h02: inv_reg = ~pl;
        8'h03: if (!tgt_drop) begin pend = inv_reg; pend_v = 1; end
        8'h04: led_reg = pl[2:0];
        8'h05: if (!tgt_drop) begin pend = {21'd0, led_reg}; pend_v = 1; end
        8'h06: begin vec[wp] = pl; wp = (wp + 1) % VEC; end
        8'h07: if (!tgt_drop) begin qcnt = VEC; rp = 0; end
        default: ;
      endcase
    end
    if (!pend_v && qcnt > 0) begin
      pend = vec[rp]; pend_v = 1; rp++; qcnt--;
    end
  endtask

  always @(negedge spi_ss_n) begin
    tgt_in = 1;
    tgt_k = 0;
    if (frames > 0) begin
      gap_seen = 1;
      if ($time - t_rise < min_gap) min_gap = $time - t_rise;
    end
    tgt_out = {pend_v ? pend : 24'd0, 1'b0, pend_v, tgt_accept, 5'd0};
    tgt_miso = tgt_out[0];
  end

  always @(posedge spi_sck) if (tgt_in) begin
    if (tgt_k < 32) tgt_rx[tgt_k] = spi_mosi;
    tgt_k++;
  end

  always @(negedge spi_sck) if (tgt_in && tgt_k < 32) tgt_miso = tgt_out[tgt_k];

  always @(posedge spi_ss_n) if (tgt_in) begin
    tgt_in = 0;
    t_rise = $time;
    if (tgt_k != 32) bad_len++;
    if (frames < 64) log_w[frames] = tgt_rx;
    frames++;
    tgt_frame(tgt_rx);
  end

  // ---------------- helpers ----------------
  logic [7:0]  r_status;
  logic [23:0] r_data;
  bit          r_fetch, r_acc, r_dok;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!cmd_ready && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check(0, req, "cmd_ready timeout", 0, 1);
  endtask

  task automatic issue(input logic [7:0] op, input logic [23:0] pl);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_payload = pl;
    wait_ready("R5");
    @(negedge clk);
    cmd_valid = 0;
    check(cmd_ready == 1'b0, "R5", "ready after accept", cmd_ready, 0);
  endtask

  task automatic get_rsp(input string req);
    int n = 0;
    @(negedge clk);
    while (!rsp_valid && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) check(0, req, "no response", 0, 1);
    r_status = rsp_status; r_data = rsp_data; r_fetch = rsp_fetch;
    r_acc = rsp_accepted; r_dok = rsp_data_ok;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R6", "watchdog expired", 0, 1);
    finish_run();
  end

  // ---------------- test sequence ----------------
  initial begin
    longint t1, t2;
    int f0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(spi_ss_n == 1'b1 && spi_sck == 1'b0, "R1", "ss/sck in reset", {spi_ss_n, spi_sck}, 2'b10);
    check(cmd_ready == 1'b0 && fetch_err == 1'b0, "R1", "ready/err in reset", {cmd_ready, fetch_err}, 0);
    rst_n = 1;

    // R1: automatic init frame
    get_rsp("R1");
    check(cmd_ready == 1'b0, "R1", "ready before init done", cmd_ready, 0);
    check(r_fetch == 1'b0, "R1", "init not a fetch", r_fetch, 0);
    wait_ready("R1");
    check(frames == 1 && log_w[0] == 32'h0000_0001, "R1", "init frame on wire", log_w[0], 32'h1);

    // table-driven commands
    for (int i = 0; i < NROW; i++) begin
      logic [7:0]  op;
      logic [23:0] pl, ex;
      int          nr;
      string       rq;
      op = TBL[i][63:56]; pl = TBL[i][55:32]; nr = int'(TBL[i][31:28]); ex = TBL[i][23:0];
      rq = (nr == 2) ? "R8" : (nr == 5) ? "R9" : "R10";
      f0 = frames;
      issue(op, pl);
      for (int j = 0; j < nr; j++) begin
        get_rsp(rq);
        check(r_fetch == (j > 0), rq, "rsp_fetch flag", r_fetch, j > 0);
        check(r_acc == 1'b1, "R7", "accepted flag", r_acc, 1);
        if (j > 0) begin
          check(r_dok == 1'b1, "R7", "reply-valid flag", r_dok, 1);
          check(r_status == 8'h60, "R6", "fetch status byte", r_status, 8'h60);
        end
        if (op == 8'h07 && j > 0)
          check(r_data == 24'(16 * j), "R9", "vector element order", r_data, 16 * j);
      end
      if (TBL[i][27:24] != 4'd0)
        check(r_data == ex, "R6", "reply field", r_data, ex);
      wait_ready(rq);
      check(frames - f0 == nr, rq, "frames per command", frames - f0, nr);
      check(log_w[f0] == {pl, op}, "R2", "frame bit order", log_w[f0], {pl, op});
      if (nr > 1)
        check(log_w[f0 + 1] == 32'h0, "R8", "fetch frame content", log_w[f0 + 1], 0);
    end

    // R3: SCK period inside a frame
    issue(8'h00, 24'h0);
    @(posedge spi_sck); t1 = $time;
    @(posedge spi_sck); t2 = $time;
    check(t2 - t1 == DIV * TCK, "R3", "sck period", t2 - t1, DIV * TCK);
    get_rsp("R10");
    check(r_dok == 1'b0, "R7", "no pending reply", r_dok, 0);
    wait_ready("R3");

    // R7: accept bit cleared by the target
    tgt_accept = 0;
    issue(8'h00, 24'h0);
    get_rsp("R7");
    check(r_acc == 1'b0 && r_status == 8'h00, "R7", "status decode", {r_acc, r_status}, 0);
    wait_ready("R7");
    tgt_accept = 1;

    check(bad_len == 0, "R2", "frames with wrong bit count", bad_len, 0);
    check(gap_seen && min_gap >= 2 * DIV * TCK, "R4", "min SS high time", min_gap, 2 * DIV * TCK);

    // R11: target withholds replies
    check(fetch_err == 1'b0, "R11", "error clear before", fetch_err, 0);
    tgt_drop = 1;
    issue(8'h03, 24'h0);
    get_rsp("R11");
    get_rsp("R11");
    check(r_fetch == 1'b1 && r_dok == 1'b0, "R11", "empty fetch", {r_fetch, r_dok}, 2'b10);
    wait_ready("R11");
    check(fetch_err == 1'b1, "R11", "error raised", fetch_err, 1);
    f0 = frames;
    issue(8'h07, 24'h0);
    for (int j = 0; j < 1 + VEC; j++) get_rsp("R11");
    wait_ready("R11");
    check(frames - f0 == 1 + VEC, "R11", "vector fetches completed", frames - f0, 1 + VEC);
    check(fetch_err == 1'b1, "R11", "error sticky", fetch_err, 1);
    tgt_drop = 0;

    // R1: reset while idle, then init again
    @(negedge clk);
    rst_n = 0;
    #1;
    check(fetch_err == 1'b0 && cmd_ready == 1'b0, "R1", "async reset clears", {fetch_err, cmd_ready}, 0);
    check(spi_ss_n == 1'b1 && spi_sck == 1'b0, "R1", "lines after reset", {spi_ss_n, spi_sck}, 2'b10);
    repeat (2) @(negedge clk);
    rst_n = 1;
    f0 = frames;
    get_rsp("R1");
    wait_ready("R1");
    check(frames - f0 == 1 && log_w[f0] == 32'h1, "R1", "init after second reset", log_w[f0], 32'h1);

    finish_run();
  end

endmodule